// File: doc/BRIEF.md
# Piezo Sweep Ramp Generator

This block produces the numeric sawtooth that steers a piezo actuator through a high-resolution DAC. Each output sample is a 24-bit code. A free-running divider turns the system clock into a sample tick, nominally 192 kHz. On every tick the block presents one new code together with a one-cycle valid strobe. While the run input is high, the code climbs from a programmable start position in steps of a programmable size. When the climb reaches the programmed span, the code drops back to the start. The full ramp is meant to repeat at well under 100 Hz, and the code maps linearly onto the optical cavity frequency.

Software writes the start position, the span and the step through a small write port into shadow registers. The sweep only picks up these values at a sweep boundary, so a sweep in progress never changes shape. A one-cycle sweep_start marker flags the sample that begins each sweep, and the capture logic uses it to align its data. When run is low, the output holds the start position.

Top module: `sweep_ramp_gen`

## Requirements
- R1: While rst is high and on the first cycle after it falls, code_valid and sweep_start are 0 and code_o is 0.
- R2: code_valid is high for exactly one clock in every TICK_DIV clocks, and every new code appears with such a strobe.
- R3: A write with cfg_we high is captured at that rising clock edge into a shadow register selected by cfg_addr. Address 0 selects the start code, address 1 the span and address 2 the step. Address 3 is ignored.
- R4: On a tick while run is low, the shadow values become active, code_o shows the start code and sweep_start is 0.
- R5: On the first tick at which run is high after a stop, code_o shows the active start code and sweep_start is 1. The accumulated offset clears to 0.
- R6: On each later tick of a sweep, the accumulated offset grows by the step and code_o equals start plus that offset.
- R7: If the offset plus the step would meet or exceed the span, that tick instead shows the start code with sweep_start = 1 and clears the offset. With a span of 0, every running tick does this.
- R8: start plus offset saturates at 0xFFFFFF and never wraps to small codes.
- R9: Shadow writes made during a sweep do not alter it. They become active at the next wrap tick.
- R10: Dropping run in the middle of a sweep makes the next tick show the start code with sweep_start = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to sweep, low to hold the start code |
| cfg_we | input | 1 | Shadow register write enable |
| cfg_addr | input | 2 | Register select: 0 start, 1 span, 2 step |
| cfg_wdata | input | 24 | Write data |
| code_o | output | 24 | DAC code |
| code_valid | output | 1 | One-cycle strobe per sample tick |
| sweep_start | output | 1 | Marks the first sample of a sweep |

## Verification
The internal tick is registered, and each code and strobe appears one clock after the tick that computes it. A shadow write counts on the tick that follows it only if the write lands before that tick, and while running it counts only at the wrap tick. The bench therefore waits for a valid strobe, does its writes or changes run within the next few clocks, and only then queues the codes expected for the following strobes. The monitor pops one expected item per strobe and also measures the spacing between strobes against TICK_DIV.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    localparam int CODE_W = 24;
    localparam int ACC_W  = CODE_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ACC_W-1:0]  acc_t;

    typedef struct packed {
        code_t start;
        code_t span;
        code_t step;
    } sweep_cfg_t;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_SPAN  = 2'd1,
        SEL_STEP  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    function automatic code_t sat_add(code_t base, acc_t off);
        logic [ACC_W:0] sum;
        sum = {2'b00, base} + {1'b0, off};
        if (sum[ACC_W:CODE_W] != '0)
            return '1;
        return sum[CODE_W-1:0];
    endfunction
endpackage

// File: rtl/sweep_tick_gen.sv
module sweep_tick_gen #(
    parameter int DIV = 521
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
endmodule

// File: rtl/sweep_cfg_regs.sv
module sweep_cfg_regs
    import sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] addr,
    input  code_t      wdata,
    output sweep_cfg_t shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                SEL_START: shadow.start <= wdata;
                SEL_SPAN:  shadow.span  <= wdata;
                SEL_STEP:  shadow.step  <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/sweep_core.sv
module sweep_core
    import sweep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  sweep_cfg_t shadow,
    output code_t      code,
    output logic       valid,
    output logic       sstart
);
    sweep_cfg_t act;
    acc_t       acc;
    acc_t       acc_next;
    logic       running;
    logic       wrap;

    always_comb begin
        acc_next = acc + {1'b0, act.step};
        wrap     = acc_next >= {1'b0, act.span};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= '0;
            acc     <= '0;
            running <= 1'b0;
            code    <= '0;
            valid   <= 1'b0;
            sstart  <= 1'b0;
        end else begin
            valid  <= tick;
            sstart <= 1'b0;
            if (tick) begin
                if (!run) begin
                    running <= 1'b0;
                    act     <= shadow;
                    acc     <= '0;
                    code    <= shadow.start;
                end else if (!running || wrap) begin
                    running <= 1'b1;
                    act     <= shadow;
                    acc     <= '0;
                    code    <= shadow.start;
                    sstart  <= 1'b1;
                end else begin
                    acc  <= acc_next;
                    code <= sat_add(act.start, acc_next);
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R2
    AST_MARK_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        sstart |-> valid); // R5
    AST_MARK_AT_START: assert property (@(posedge clk) disable iff (rst)
        sstart |-> (code == act.start)); // R7
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (valid && !running) |-> (code == act.start && !sstart)); // R4
    AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (valid && running) |-> (code >= act.start)); // R8
    AST_ACC_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        (running && act.span != '0) |-> (acc < {1'b0, act.span})); // R6
endmodule

// File: rtl/sweep_ramp_gen.sv
module sweep_ramp_gen
    import sweep_pkg::*;
#(
    parameter int TICK_DIV = 521
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CODE_W-1:0] cfg_wdata,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid,
    output logic              sweep_start
);
    logic       tick;
    sweep_cfg_t shadow;

    sweep_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sweep_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .shadow (shadow)
    );

    sweep_core u_core (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .run    (run),
        .shadow (shadow),
        .code   (code_o),
        .valid  (code_valid),
        .sstart (sweep_start)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!code_valid && !sweep_start && code_o == '0)); // R1
endmodule

// File: tb/sweep_ramp_gen_bench.sv
module sweep_ramp_gen_bench;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] code_o;
    logic        code_valid;
    logic        sweep_start;

    typedef struct {
        logic [23:0] code;
        logic        mark;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   last_v = -1;
    bit   done = 0;

    always #5 clk = ~clk;

    sweep_ramp_gen #(.TICK_DIV(DIV)) u_sweep_ramp_gen (
        .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .code_o(code_o), .code_valid(code_valid), .sweep_start(sweep_start)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (!rst && code_valid) begin
            if (last_v >= 0) begin
                n_chk++;
                if (cyc - last_v != DIV) begin
                    n_bad++;
                    $display("FAIL R2 strobe spacing actual=%0d expected=%0d", cyc - last_v, DIV);
                end
            end
            last_v = cyc;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (code_o !== e.code || sweep_start !== e.mark) begin
                    n_bad++;
                    $display("FAIL %s code/mark actual=%06h/%0b expected=%06h/%0b",
                             e.tag, code_o, sweep_start, e.code, e.mark);
                end
            end
        end
    end

    task automatic wait_valid();
        @(negedge clk);
        while (!code_valid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic item(input logic [23:0] c, input logic m, input string t);
        exp_t e;
        e.code = c; e.mark = m; e.tag = t;
        exp_q.push_back(e);
        wait_valid();
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg3(input logic [23:0] s, input logic [23:0] sp, input logic [23:0] st);
        wr(2'd0, s); wr(2'd1, sp); wr(2'd2, st);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        n_chk++;
        if (code_valid !== 1'b0 || sweep_start !== 1'b0 || code_o !== 24'h0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual=%06h/%0b/%0b expected=000000/0/0",
                     code_o, code_valid, sweep_start);
        end
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (code_valid !== 1'b0 || code_o !== 24'h0) begin
            n_bad++;
            $display("FAIL R1 after reset actual=%06h/%0b expected=000000/0", code_o, code_valid);
        end
        wait_valid();
        // R3 writes, R4 stopped shows shadow start
        cfg3(24'h000100, 24'h000040, 24'h000010);
        item(24'h000100, 1'b0, "R4/R3 stopped start");
        wr(2'd3, 24'h00ABCD);
        item(24'h000100, 1'b0, "R3 address 3 ignored");
        run = 1'b1;
        item(24'h000100, 1'b1, "R5 first run tick");
        item(24'h000110, 1'b0, "R6 ramp");
        item(24'h000120, 1'b0, "R6 ramp");
        item(24'h000130, 1'b0, "R6 ramp");
        item(24'h000100, 1'b1, "R7 wrap");
        item(24'h000110, 1'b0, "R6 ramp after wrap");
        // R9: mid-sweep writes wait for the wrap
        wr(2'd0, 24'h000300); wr(2'd1, 24'h000020);
        item(24'h000120, 1'b0, "R9 old config kept");
        item(24'h000130, 1'b0, "R9 old config kept");
        item(24'h000300, 1'b1, "R9 new config at wrap");
        item(24'h000310, 1'b0, "R6 new ramp");
        // R10: stop mid-sweep
        run = 1'b0;
        item(24'h000300, 1'b0, "R10 stop mid-sweep");
        cfg3(24'h000200, 24'h000025, 24'h000010);
        item(24'h000200, 1'b0, "R4 stopped reload");
        run = 1'b1;
        item(24'h000200, 1'b1, "R5 restart");
        item(24'h000210, 1'b0, "R6 ramp");
        item(24'h000220, 1'b0, "R6 ramp");
        item(24'h000200, 1'b1, "R7 wrap on exceed");
        // span of zero
        wr(2'd1, 24'h000000);
        item(24'h000210, 1'b0, "R9 span write pending");
        item(24'h000220, 1'b0, "R9 span write pending");
        item(24'h000200, 1'b1, "R7 wrap loads span 0");
        item(24'h000200, 1'b1, "R7 span 0 every tick");
        // R8 saturation
        cfg3(24'hFFFFF0, 24'h000100, 24'h000008);
        item(24'hFFFFF0, 1'b1, "R8 start near top");
        item(24'hFFFFF8, 1'b0, "R8 below top");
        item(24'hFFFFFF, 1'b0, "R8 saturated");
        item(24'hFFFFFF, 1'b0, "R8 saturated");
        run = 1'b0;
        item(24'hFFFFF0, 1'b0, "R10 stop");
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 pending items actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule